// File: doc/BRIEF.md
# Multi-Term Capture Trigger Qualifier

This block decides when a signal-capture engine should fire. Every clock it watches a 32-bit debug word, four small status fields and a set of configuration inputs. When the selected trigger condition turns true it issues a one-clock pulse on `trig_pulse`. The capture engine uses that pulse to freeze or start its sample window.

There are three trigger sources, chosen by a mode input:
- **Single-bit source.** One bit of the debug word, picked by a 5-bit index, with a choice of rising or falling edge. In this mode the condition can be narrowed by up to three small field comparisons and one wide 32-bit masked comparison, all combined by AND.
- **Masked-match source.** The debug word, ANDed with a mask, is compared to a reference value.
- **Manual source.** Software sets a stored bit from 0 to 1.

A control bit can remove the single bit from the AND chain, so that the qualifier terms alone decide.

The combined condition is registered. Only a low-to-high change of that registered condition produces the output pulse. A condition that stays true therefore triggers once. A condition that is already true when reset is released does not trigger at all.

Top module: `trig_qualifier`

## Requirements
- R1: `cfg_mode` selects the source: 0 = single debug bit, 1 = masked match, 2 = manual bit, 3 = no source. With 3 the pulse never fires.
- R2: In mode 0 the source bit is `dbg_word[cfg_bit_sel]`. With `cfg_edge`=0 a 0-to-1 change of that bit fires, and with `cfg_edge`=1 a 1-to-0 change fires. The pulse is high in the clock after the edge that first samples the new bit value.
- R3: In mode 1 the match is `(dbg_word & cfg_mac_mask) == cfg_mac_ref`. `cfg_edge`=0 fires when the match begins and `cfg_edge`=1 fires when it ends, with the same latency as R2.
- R4: A write (`man_wr`=1) stores `man_wr_data` in the manual bit. In mode 2, a write of 1 while the bit is 0 makes the pulse high in the second clock after the write edge. Writing 1 while the bit is already 1 gives no pulse. `cfg_edge` has no effect in mode 2.
- R5: Qualifier term i (i = 0, 1, 2) takes its selector from `cfg_term_sel[4i+3:4i]`, its value from `cfg_term_val[5i+4:5i]` and its invert flag from `cfg_term_inv[i]`.
  - Selector 4, 5 and 6 compare `fld_a`, `fld_b` and `fld_c` with the 5-bit value.
  - Selector 7 compares `fld_d` with the value's low 4 bits; value bit 4 is ignored.
  - Any other nonzero selector never matches.
  - For a nonzero selector the invert flag flips the result.
  - Selector 0 means the term is always true, whatever the invert flag.
- R6: The wide term is off (always true) when `cfg_wide_en` is 0. Otherwise it is true when `(dbg_word & cfg_wide_en) == (cfg_wide_val & cfg_wide_en)`. Value bits outside the enable mask are ignored.
- R7: In mode 0 the condition is the edge-adjusted source bit ANDed with all four terms. In modes 1 and 2 the terms have no effect.
- R8: `cfg_ori_dis`=1 drops the source bit from the mode-0 condition, but only while at least one term is on. When every term is off, `cfg_ori_dis` has no effect.
- R9: Each pulse lasts exactly one clock. A condition held true produces no further pulse until it has gone false and then true again.
- R10: While `rst_n` is low the pulse is 0. A condition that is already true when reset is released gives no pulse until it has gone false and then true again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_word | input | 32 | Debug word under observation |
| fld_a | input | 5 | Status field compared by selector 4 |
| fld_b | input | 5 | Status field compared by selector 5 |
| fld_c | input | 5 | Status field compared by selector 6 |
| fld_d | input | 4 | Status field compared by selector 7 |
| cfg_mode | input | 2 | Source select (R1) |
| cfg_bit_sel | input | 5 | Index of the source bit |
| cfg_edge | input | 1 | 0 = rising, 1 = falling |
| cfg_mac_mask | input | 32 | Mask for the masked-match source |
| cfg_mac_ref | input | 32 | Reference for the masked-match source |
| cfg_ori_dis | input | 1 | Drop the source bit when any term is on |
| cfg_term_sel | input | 12 | Three 4-bit term selectors |
| cfg_term_val | input | 15 | Three 5-bit term values |
| cfg_term_inv | input | 3 | Three term invert flags |
| cfg_wide_en | input | 32 | Enable mask of the wide term |
| cfg_wide_val | input | 32 | Compare value of the wide term |
| man_wr | input | 1 | Manual bit write strobe |
| man_wr_data | input | 1 | Data written to the manual bit |
| trig_pulse | output | 1 | One-clock trigger pulse |

## Verification
The hardest case to reach is a pulse in which each ingredient of the mode-0 chain has to matter on its own: the single bit, one field term with a narrowed or inverted compare, and the wide term. Every other input must be held so that the pulse follows from that one change alone.

The stimulus table reaches this in pairs of steps. Each pair first leaves exactly one term false and then flips only that term. The rising edge of the registered condition is therefore caused by that term and nothing else. This is how the invert flag, the ignored value bit of selector 7 and the bypass of the source bit become visible.

Directed sequences then cover the manual bit's two-clock latency and its repeated-write case, and a condition that is held true across reset release.

// File: rtl/ctq_pkg.sv
package ctq_pkg;

  localparam int SEL_W   = 4;
  localparam int FVAL_W  = 5;
  localparam int NIB_W   = 4;

  typedef enum logic [1:0] {
    SRC_BIT = 2'd0,
    SRC_MAC = 2'd1,
    SRC_MAN = 2'd2,
    SRC_OFF = 2'd3
  } trig_src_e;

  // Raw field comparison for one qualifier term (before inversion).
  function automatic logic f_field_match(
    input logic [SEL_W-1:0]  sel,
    input logic [FVAL_W-1:0] val,
    input logic [FVAL_W-1:0] fa,
    input logic [FVAL_W-1:0] fb,
    input logic [FVAL_W-1:0] fc,
    input logic [NIB_W-1:0]  fd
  );
    logic m;
    case (sel)
      4'd4:    m = (fa == val);
      4'd5:    m = (fb == val);
      4'd6:    m = (fc == val);
      4'd7:    m = (fd == val[NIB_W-1:0]);
      default: m = 1'b0;
    endcase
    return m;
  endfunction

  // Masked equality: only bits set in en take part.
  function automatic logic f_masked_eq(
    input logic [31:0] word,
    input logic [31:0] en,
    input logic [31:0] val
  );
    return ((word & en) == (val & en));
  endfunction

endpackage

// File: rtl/ctq_and_term.sv
module ctq_and_term
  import ctq_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic [FVAL_W-1:0] val,
  input  logic              inv,
  input  logic [FVAL_W-1:0] fa,
  input  logic [FVAL_W-1:0] fb,
  input  logic [FVAL_W-1:0] fc,
  input  logic [NIB_W-1:0]  fd,
  output logic              active,
  output logic              hit
);

  logic raw_match;

  always_comb begin
    raw_match = f_field_match(sel, val, fa, fb, fc, fd);
    active    = (sel != '0);
    hit       = active ? (raw_match ^ inv) : 1'b1;
  end

endmodule

// File: rtl/ctq_source.sv
module ctq_source
  import ctq_pkg::*;
#(
  parameter int DW     = 32,
  parameter int BSEL_W = $clog2(DW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     dbg_word,
  input  logic [BSEL_W-1:0] bit_sel,
  input  logic [DW-1:0]     mac_mask,
  input  logic [DW-1:0]     mac_ref,
  input  logic              man_wr,
  input  logic              man_wr_data,
  output logic              src_bit,
  output logic              mac_match,
  output logic              man_bit
);

  always_comb begin
    src_bit   = dbg_word[bit_sel];
    mac_match = ((dbg_word & mac_mask) == mac_ref);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      man_bit <= 1'b0;
    else if (man_wr) man_bit <= man_wr_data;
  end

  // R4: without a write strobe the manual bit keeps its value
  p_man_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !man_wr |=> $stable(man_bit));

  // R4: a write strobe lands its data in the manual bit
  p_man_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    man_wr |=> (man_bit == $past(man_wr_data)));

endmodule

// File: rtl/ctq_edge_pulse.sv
module ctq_edge_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_in,
  output logic cond_q,
  output logic pulse
);

  // cond_q resets high so that a condition already true at release
  // cannot look like a fresh rise.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q <= 1'b1;
      pulse  <= 1'b0;
    end else begin
      cond_q <= cond_in;
      pulse  <= cond_in & ~cond_q;
    end
  end

  // R9: a pulse is never longer than one clock
  p_one_clock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  // R9: a pulse is always paired with a low-to-high registered condition
  p_rise_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (cond_q && !$past(cond_q)));

  // R10: no pulse while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) a_rst_quiet_r10: assert (!pulse || $past(rst_n));
  end

endmodule

// File: rtl/trig_qualifier.sv
module trig_qualifier
  import ctq_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NTERM = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DW-1:0]           dbg_word,
  input  logic [FVAL_W-1:0]       fld_a,
  input  logic [FVAL_W-1:0]       fld_b,
  input  logic [FVAL_W-1:0]       fld_c,
  input  logic [NIB_W-1:0]        fld_d,
  input  logic [1:0]              cfg_mode,
  input  logic [$clog2(DW)-1:0]   cfg_bit_sel,
  input  logic                    cfg_edge,
  input  logic [DW-1:0]           cfg_mac_mask,
  input  logic [DW-1:0]           cfg_mac_ref,
  input  logic                    cfg_ori_dis,
  input  logic [NTERM*SEL_W-1:0]  cfg_term_sel,
  input  logic [NTERM*FVAL_W-1:0] cfg_term_val,
  input  logic [NTERM-1:0]        cfg_term_inv,
  input  logic [DW-1:0]           cfg_wide_en,
  input  logic [DW-1:0]           cfg_wide_val,
  input  logic                    man_wr,
  input  logic                    man_wr_data,
  output logic                    trig_pulse
);

  localparam int BSEL_W = $clog2(DW);

  logic             src_bit, mac_match, man_bit;
  logic [NTERM-1:0] term_active, term_hit;
  logic             wide_active, wide_hit;
  logic             any_term, use_src, bit_level, bit_cond, cond_now, cond_q;
  trig_src_e        mode;

  ctq_source #(.DW(DW), .BSEL_W(BSEL_W)) u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .dbg_word   (dbg_word),
    .bit_sel    (cfg_bit_sel),
    .mac_mask   (cfg_mac_mask),
    .mac_ref    (cfg_mac_ref),
    .man_wr     (man_wr),
    .man_wr_data(man_wr_data),
    .src_bit    (src_bit),
    .mac_match  (mac_match),
    .man_bit    (man_bit)
  );

  for (genvar g = 0; g < NTERM; g++) begin : g_term
    ctq_and_term u_term (
      .sel   (cfg_term_sel[g*SEL_W +: SEL_W]),
      .val   (cfg_term_val[g*FVAL_W +: FVAL_W]),
      .inv   (cfg_term_inv[g]),
      .fa    (fld_a),
      .fb    (fld_b),
      .fc    (fld_c),
      .fd    (fld_d),
      .active(term_active[g]),
      .hit   (term_hit[g])
    );

    // R5: an unused selector leaves the term satisfied
    p_sel_zero_true_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_term_sel[g*SEL_W +: SEL_W] == '0) |-> term_hit[g]);
  end

  always_comb begin
    mode        = trig_src_e'(cfg_mode);
    wide_active = (cfg_wide_en != '0);
    wide_hit    = wide_active ? f_masked_eq(dbg_word, cfg_wide_en, cfg_wide_val) : 1'b1;
    any_term    = (|term_active) | wide_active;
    use_src     = !(cfg_ori_dis && any_term);
    bit_level   = src_bit ^ cfg_edge;
    bit_cond    = (use_src ? bit_level : 1'b1) & (&term_hit) & wide_hit;
    case (mode)
      SRC_BIT: cond_now = bit_cond;
      SRC_MAC: cond_now = mac_match ^ cfg_edge;
      SRC_MAN: cond_now = man_bit;
      default: cond_now = 1'b0;
    endcase
  end

  ctq_edge_pulse u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .cond_in(cond_now),
    .cond_q (cond_q),
    .pulse  (trig_pulse)
  );

  // R1: no pulse can follow a clock spent with no source selected
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> ($past(cfg_mode) != SRC_OFF));

  // R6: an empty enable mask never blocks the chain
  p_wide_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wide_en == '0) |-> wide_hit);

  // R3: a rising-edge masked-match pulse follows a sampled match
  p_mac_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && $past(cfg_mode) == SRC_MAC && !$past(cfg_edge)) |-> $past(mac_match));

  // R7: a mode-0 pulse needs every term satisfied when sampled
  p_terms_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && $past(cfg_mode) == SRC_BIT) |-> ($past(&term_hit) && $past(wide_hit)));

  // R4: a manual pulse needs the stored bit set
  p_man_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && $past(cfg_mode) == SRC_MAN) |-> $past(man_bit));

endmodule

// File: tb/trig_qualifier_test.sv
module trig_qualifier_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] dbg_word;
  logic [4:0]  fld_a, fld_b, fld_c;
  logic [3:0]  fld_d;
  logic [1:0]  cfg_mode;
  logic [4:0]  cfg_bit_sel;
  logic        cfg_edge;
  logic [31:0] cfg_mac_mask, cfg_mac_ref;
  logic        cfg_ori_dis;
  logic [11:0] cfg_term_sel;
  logic [14:0] cfg_term_val;
  logic [2:0]  cfg_term_inv;
  logic [31:0] cfg_wide_en, cfg_wide_val;
  logic        man_wr, man_wr_data;
  logic        trig_pulse;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  trig_qualifier uut (
    .clk(clk), .rst_n(rst_n), .dbg_word(dbg_word),
    .fld_a(fld_a), .fld_b(fld_b), .fld_c(fld_c), .fld_d(fld_d),
    .cfg_mode(cfg_mode), .cfg_bit_sel(cfg_bit_sel), .cfg_edge(cfg_edge),
    .cfg_mac_mask(cfg_mac_mask), .cfg_mac_ref(cfg_mac_ref),
    .cfg_ori_dis(cfg_ori_dis), .cfg_term_sel(cfg_term_sel),
    .cfg_term_val(cfg_term_val), .cfg_term_inv(cfg_term_inv),
    .cfg_wide_en(cfg_wide_en), .cfg_wide_val(cfg_wide_val),
    .man_wr(man_wr), .man_wr_data(man_wr_data), .trig_pulse(trig_pulse)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        edg;
    logic [4:0]  bsel;
    logic        odis;
    logic [11:0] tsel;
    logic [14:0] tval;
    logic [2:0]  tinv;
    logic [31:0] wen;
    logic [31:0] wval;
    logic [31:0] dbg;
    logic [4:0]  fa;
    logic [3:0]  fd;
    logic        exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 38;
  // One step per clock; exp is trig_pulse one clock after the step is applied.
  localparam vec_t VECS [NV] = '{
    // R2 rising edge on bit 5, R9 no repeat
    '{2'd0,1'b0,5'd5, 1'b0,12'h000,15'h0000,3'b000,32'h0,32'h0,32'h0,5'd0,4'h0,1'b0,8'd2},
    '{2'd0,1'b0,5'd5, 1'b0,12'h000,15'h0000,3'b000,32'h0,32'h0,32'h00000020,5'd0,4'h0,1'b1,8'd2},
    '{2'd0,1'b0,5'd5, 1'b0,12'h000,15'h0000,3'b000,32'h0,32'h0,32'h00000020,5'd0,4'h0,1'b0,8'd9},
    // R2 falling edge
    '{2'd0,1'b1,5'd5, 1'b0,12'h000,15'h0000,3'b000,32'h0,32'h0,32'h00000020,5'd0,4'h0,1'b0,8'd2},
    '{2'd0,1'b1,5'd5, 1'b0,12'h000,15'h0000,3'b000,32'h0,32'h0,32'h0,5'd0,4'h0,1'b1,8'd2},
    '{2'd0,1'b1,5'd5, 1'b0,12'h000,15'h0000,3'b000,32'h0,32'h0,32'h0,5'd0,4'h0,1'b0,8'd9},
    // R2 index boundaries 31 and 0
    '{2'd0,1'b0,5'd31,1'b0,12'h000,15'h0000,3'b000,32'h0,32'h0,32'h0,5'd0,4'h0,1'b0,8'd2},
    '{2'd0,1'b0,5'd31,1'b0,12'h000,15'h0000,3'b000,32'h0,32'h0,32'h80000000,5'd0,4'h0,1'b1,8'd2},
    '{2'd0,1'b0,5'd0, 1'b0,12'h000,15'h0000,3'b000,32'h0,32'h0,32'h80000000,5'd0,4'h0,1'b0,8'd2},
    '{2'd0,1'b0,5'd0, 1'b0,12'h000,15'h0000,3'b000,32'h0,32'h0,32'h00000001,5'd0,4'h0,1'b1,8'd2},
    // R5/R7 field term 0, selector 4 value 3
    '{2'd0,1'b0,5'd0, 1'b0,12'h000,15'h0000,3'b000,32'h0,32'h0,32'h0,5'd0,4'h0,1'b0,8'd7},
    '{2'd0,1'b0,5'd0, 1'b0,12'h004,15'h0003,3'b000,32'h0,32'h0,32'h00000001,5'd0,4'h0,1'b0,8'd7},
    '{2'd0,1'b0,5'd0, 1'b0,12'h004,15'h0003,3'b000,32'h0,32'h0,32'h00000001,5'd3,4'h0,1'b1,8'd5},
    // R5 invert flag
    '{2'd0,1'b0,5'd0, 1'b0,12'h004,15'h0003,3'b000,32'h0,32'h0,32'h00000001,5'd0,4'h0,1'b0,8'd5},
    '{2'd0,1'b0,5'd0, 1'b0,12'h004,15'h0003,3'b001,32'h0,32'h0,32'h00000001,5'd0,4'h0,1'b1,8'd5},
    '{2'd0,1'b0,5'd0, 1'b0,12'h004,15'h0003,3'b001,32'h0,32'h0,32'h00000001,5'd3,4'h0,1'b0,8'd5},
    // R5 term 1 selector 7, value bit 4 ignored
    '{2'd0,1'b0,5'd0, 1'b0,12'h070,15'h0340,3'b000,32'h0,32'h0,32'h00000001,5'd0,4'hA,1'b1,8'd5},
    '{2'd0,1'b0,5'd0, 1'b0,12'h070,15'h0340,3'b000,32'h0,32'h0,32'h00000001,5'd0,4'hB,1'b0,8'd5},
    // R5 unsupported selector blocks, selector 0 ignores invert
    '{2'd0,1'b0,5'd0, 1'b0,12'h200,15'h0000,3'b000,32'h0,32'h0,32'h00000001,5'd0,4'h0,1'b0,8'd5},
    '{2'd0,1'b0,5'd0, 1'b0,12'h000,15'h0000,3'b111,32'h0,32'h0,32'h00000001,5'd0,4'h0,1'b1,8'd5},
    // R6 wide term
    '{2'd0,1'b0,5'd0, 1'b0,12'h000,15'h0000,3'b000,32'h0000FF00,32'h00001200,32'h00003401,5'd0,4'h0,1'b0,8'd6},
    '{2'd0,1'b0,5'd0, 1'b0,12'h000,15'h0000,3'b000,32'h0000FF00,32'h00001200,32'h00001201,5'd0,4'h0,1'b1,8'd6},
    '{2'd0,1'b0,5'd0, 1'b0,12'h000,15'h0000,3'b000,32'h0000FF00,32'h00001200,32'h0,5'd0,4'h0,1'b0,8'd6},
    '{2'd0,1'b0,5'd0, 1'b0,12'h000,15'h0000,3'b000,32'h0000FF00,32'hFFFF12FF,32'h00001201,5'd0,4'h0,1'b1,8'd6},
    // R8 source bit dropped while a term is on
    '{2'd0,1'b0,5'd0, 1'b1,12'h000,15'h0000,3'b000,32'h0000FF00,32'h00001200,32'h00003400,5'd0,4'h0,1'b0,8'd8},
    '{2'd0,1'b0,5'd0, 1'b1,12'h000,15'h0000,3'b000,32'h0000FF00,32'h00001200,32'h00001200,5'd0,4'h0,1'b1,8'd8},
    // R8 no effect with every term off
    '{2'd0,1'b0,5'd0, 1'b1,12'h000,15'h0000,3'b000,32'h0,32'h0,32'h0,5'd0,4'h0,1'b0,8'd8},
    '{2'd0,1'b0,5'd0, 1'b1,12'h000,15'h0000,3'b000,32'h0,32'h0,32'h00000001,5'd0,4'h0,1'b1,8'd8},
    // R3 masked match, mask 00FF00F0 ref 00120030
    '{2'd1,1'b0,5'd0, 1'b0,12'h000,15'h0000,3'b000,32'h0,32'h0,32'h0,5'd0,4'h0,1'b0,8'd3},
    '{2'd1,1'b0,5'd0, 1'b0,12'h000,15'h0000,3'b000,32'h0,32'h0,32'hAB12CD3E,5'd0,4'h0,1'b1,8'd3},
    '{2'd1,1'b0,5'd0, 1'b0,12'h000,15'h0000,3'b000,32'h0,32'h0,32'h00120031,5'd0,4'h0,1'b0,8'd9},
    '{2'd1,1'b1,5'd0, 1'b0,12'h000,15'h0000,3'b000,32'h0,32'h0,32'h00120030,5'd0,4'h0,1'b0,8'd3},
    '{2'd1,1'b1,5'd0, 1'b0,12'h000,15'h0000,3'b000,32'h0,32'h0,32'h0,5'd0,4'h0,1'b1,8'd3},
    // R7 failing field term has no effect in mode 1
    '{2'd1,1'b0,5'd0, 1'b0,12'h004,15'h0003,3'b000,32'h0,32'h0,32'h0,5'd0,4'h0,1'b0,8'd7},
    '{2'd1,1'b0,5'd0, 1'b0,12'h004,15'h0003,3'b000,32'h0,32'h0,32'h00120030,5'd0,4'h0,1'b1,8'd7},
    // R1 mode 3 never fires
    '{2'd3,1'b0,5'd0, 1'b0,12'h000,15'h0000,3'b000,32'h0,32'h0,32'h00120030,5'd0,4'h0,1'b0,8'd1},
    '{2'd3,1'b0,5'd0, 1'b0,12'h000,15'h0000,3'b000,32'h0,32'h0,32'h0,5'd0,4'h0,1'b0,8'd1},
    '{2'd3,1'b0,5'd0, 1'b0,12'h000,15'h0000,3'b000,32'h0,32'h0,32'h00120030,5'd0,4'h0,1'b0,8'd1}
  };

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: trig_pulse=%b expected %b", req, what, got, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    cfg_mode = v.mode; cfg_edge = v.edg; cfg_bit_sel = v.bsel;
    cfg_ori_dis = v.odis; cfg_term_sel = v.tsel; cfg_term_val = v.tval;
    cfg_term_inv = v.tinv; cfg_wide_en = v.wen; cfg_wide_val = v.wval;
    dbg_word = v.dbg; fld_a = v.fa; fld_d = v.fd;
  endtask

  task automatic man_write(input logic d);
    man_wr = 1'b1; man_wr_data = d;
    @(negedge clk);
    man_wr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; dbg_word = '0; fld_a = '0; fld_b = '0; fld_c = '0; fld_d = '0;
    cfg_mode = 2'd0; cfg_bit_sel = '0; cfg_edge = 1'b0;
    cfg_mac_mask = 32'h00FF00F0; cfg_mac_ref = 32'h00120030;
    cfg_ori_dis = 1'b0; cfg_term_sel = '0; cfg_term_val = '0; cfg_term_inv = '0;
    cfg_wide_en = '0; cfg_wide_val = '0; man_wr = 1'b0; man_wr_data = 1'b0;
    repeat (3) @(negedge clk);
    chk(trig_pulse, 1'b0, "R10", "reset state");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      @(negedge clk);
      chk(trig_pulse, VECS[i].exp, $sformatf("R%0d", VECS[i].req), $sformatf("vector %0d", i));
    end

    // R4 manual bit: switch to mode 2 with stored bit 0
    cfg_mode = 2'd2; dbg_word = '0; cfg_term_sel = '0;
    @(negedge clk);
    chk(trig_pulse, 1'b0, "R4", "mode 2 idle");
    man_write(1'b1);
    chk(trig_pulse, 1'b0, "R4", "one clock after write");
    @(negedge clk);
    chk(trig_pulse, 1'b1, "R4", "two clocks after write");
    @(negedge clk);
    chk(trig_pulse, 1'b0, "R9", "manual pulse width");
    man_write(1'b1);
    chk(trig_pulse, 1'b0, "R4", "rewrite 1, clock 1");
    @(negedge clk);
    chk(trig_pulse, 1'b0, "R4", "rewrite 1, clock 2");
    cfg_edge = 1'b1;
    man_write(1'b0);
    @(negedge clk);
    chk(trig_pulse, 1'b0, "R4", "write 0");
    man_write(1'b1);
    chk(trig_pulse, 1'b0, "R4", "edge=1 clock 1");
    @(negedge clk);
    chk(trig_pulse, 1'b1, "R4", "edge=1 has no effect");

    // R10 condition held true across reset release
    cfg_mode = 2'd0; cfg_edge = 1'b0; cfg_bit_sel = 5'd0; dbg_word = 32'h1;
    rst_n = 1'b0;
    @(negedge clk);
    chk(trig_pulse, 1'b0, "R10", "held in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(trig_pulse, 1'b0, "R10", "true at release, clock 1");
    @(negedge clk);
    chk(trig_pulse, 1'b0, "R10", "true at release, clock 2");
    dbg_word = 32'h0;
    @(negedge clk);
    chk(trig_pulse, 1'b0, "R10", "condition drops");
    dbg_word = 32'h1;
    @(negedge clk);
    chk(trig_pulse, 1'b1, "R10", "first rise after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run stalled, got no end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule